// File: doc/BRIEF.md
# Multi-Mode PWM Time Base

This block is the counting core of a motor-drive PWM unit. A 15-bit timer counts scaled clock ticks up to a programmable period. It runs in one of four ways: a free-running sawtooth for edge-aligned waveforms, a single pulse that stops by itself, a continuous triangle for center-aligned waveforms, and a triangle that also takes new duty values at the peak. The block feeds four duty-cycle comparators. Each comparator works from an active duty copy that reloads from a write buffer only at fixed points of the count, so a write never cuts a pulse short.

The block also gives two timing pulses. The first is a period interrupt, which can be thinned by a postscaler. The second is a start pulse for an A/D converter, raised where the count meets a compare value while it moves in a chosen direction. Software programs the block through a plain write-only register port: an enable, a strobe, an address and data.

Top module: `pwm_timebase`

## Requirements
- R1: After reset `pwm_out`, `tmr_value`, `tmr_dir`, `running`, `period_irq`, `adc_trig` and `oneshot_done` are all zero.
- R2: Control bits 4:3 choose the clocks per count step: 0 gives 1, 1 gives 4, 2 gives 16 and 3 gives 64. After start the timer shows 0 for that many cycles before it first steps.
- R3: Control bits 2:1 set to 0 select free-running. The timer steps 0,1,…,P and then back to 0, where P is the period register, and `tmr_dir` stays 0.
- R4: Mode 2 (up/down) and mode 3 (up/down with double update) need P ≥ 2. The timer steps 0 up to P and then P−1 down to 1, then shows 0 again. `tmr_dir` is 1 exactly while it steps down.
- R5: Mode 1 is single-shot. The timer counts 0..P once. On the step after P it returns to 0, clears the enable bit, drops `running`, and pulses `oneshot_done` high for one cycle.
- R6: While `running` is 0, the timer is held at 0, `tmr_dir` is 0 and all `pwm_out` bits are 0. Writing control bit 0 as 0 stops the timer at once.
- R7: A duty write goes to a buffer. The active copy takes the buffer value at start and on every step where the timer returns to 0.
- R8: In mode 3 the active copies also reload on the step where the count turns from rising to falling.
- R9: While running, `pwm_out[i]` is 1 exactly when active duty D is non-zero and either D ≥ P or the timer value is below D. So D = 0 keeps the output low and D ≥ P keeps it high.
- R10: `period_irq` pulses one cycle, in the cycle the timer first shows 0 after a return to zero, on every (N+1)th such return. N is control bits 8:5, and the count of returns restarts at each start.
- R11: `adc_trig` pulses one cycle in the first cycle the timer shows the compare value while `tmr_dir` equals the compare direction. The compare value is address 2 bits 14:0 and the direction is bit 15.
- R12: Register addresses are 0 for control, 1 for period (bits 14:0), 2 for compare, and 3 to 6 for duty buffers of channels 0 to 3. Writing control with bit 0 set while stopped starts the count from 0, and `running` goes to 1 the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 4 | Comparator outputs, one per channel |
| tmr_value | output | 15 | Current timer value |
| tmr_dir | output | 1 | 1 while counting down |
| running | output | 1 | Timer is counting |
| period_irq | output | 1 | Postscaled period interrupt pulse |
| adc_trig | output | 1 | A/D conversion start pulse |
| oneshot_done | output | 1 | End of a single-shot run |

## Verification
The assertions watch, on every cycle, the things that need no memory of the setup. The timer rests at zero with quiet outputs when stopped, and it moves by exactly one step or falls to zero. The interrupt only lands on a zero with a rising direction. The trigger only lands on the compare value in the chosen direction, and the single-shot end pulse is lone and leaves the timer parked. Other properties depend on the full register history and can only be shown by the bench scenarios against its reference model. These are exact prescale spacing, turnaround points, when buffered duties take effect (including the mid-peak reload), postscale spacing, and the duty boundary values 0 and ≥ P.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;

    typedef enum logic [1:0] {
        MODE_FREE       = 2'd0,
        MODE_ONESHOT    = 2'd1,
        MODE_UPDOWN     = 2'd2,
        MODE_UPDOWN_DBL = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RISE = 2'd1,
        ST_FALL = 2'd2
    } tb_state_e;

    localparam int POST_W     = 4;
    localparam int PS_W       = 6;
    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_PER   = 1;
    localparam int ADDR_CMP   = 2;
    localparam int ADDR_DUTY0 = 3;

    typedef struct packed {
        logic [POST_W-1:0] post;
        logic [1:0]        presc;
        cnt_mode_e         mode;
        logic              en;
    } ctrl_t;

    localparam int CTRL_BITS = $bits(ctrl_t);

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler import pwmtb_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clr,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [PS_W-1:0] cnt_q;
    logic [PS_W-1:0] div_m1;

    always_comb begin
        unique case (sel)
            2'd0: div_m1 = PS_W'(0);
            2'd1: div_m1 = PS_W'(3);
            2'd2: div_m1 = PS_W'(15);
            2'd3: div_m1 = PS_W'(63);
        endcase
    end

    assign tick = run && !clr && (cnt_q >= div_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (clr || !run)    cnt_q <= '0;
        else if (tick)           cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pwm_count_fsm.sv
module pwm_count_fsm import pwmtb_pkg::*; #(
    parameter int TMR_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             tick,
    input  cnt_mode_e        mode,
    input  logic [TMR_W-1:0] period,
    output logic [TMR_W-1:0] tmr_q,
    output logic [TMR_W-1:0] tmr_nx,
    output logic             dir_q,
    output logic             dir_nx,
    output logic             run,
    output logic             zero_evt,
    output logic             top_evt,
    output logic             shot_end
);
    tb_state_e state_q, state_nx;

    // next-state and event decode
    always_comb begin
        state_nx = state_q;
        tmr_nx   = tmr_q;
        zero_evt = 1'b0;
        top_evt  = 1'b0;
        shot_end = 1'b0;
        if (stop) begin
            state_nx = ST_IDLE;
            tmr_nx   = '0;
        end else if (start) begin
            state_nx = ST_RISE;
            tmr_nx   = '0;
        end else if (tick) begin
            unique case (state_q)
                ST_IDLE: begin
                    tmr_nx = '0;
                end
                ST_RISE: begin
                    if (tmr_q >= period) begin
                        if (mode == MODE_FREE) begin
                            tmr_nx   = '0;
                            zero_evt = 1'b1;
                        end else if (mode == MODE_ONESHOT) begin
                            tmr_nx   = '0;
                            zero_evt = 1'b1;
                            shot_end = 1'b1;
                            state_nx = ST_IDLE;
                        end else begin
                            top_evt  = 1'b1;
                            state_nx = ST_FALL;
                            tmr_nx   = (tmr_q == '0) ? '0 : tmr_q - 1'b1;
                        end
                    end else begin
                        tmr_nx = tmr_q + 1'b1;
                    end
                end
                ST_FALL: begin
                    if (tmr_q <= TMR_W'(1)) begin
                        tmr_nx   = '0;
                        zero_evt = 1'b1;
                        state_nx = ST_RISE;
                    end else begin
                        tmr_nx = tmr_q - 1'b1;
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
        end else begin
            state_q <= state_nx;
            tmr_q   <= tmr_nx;
        end
    end

    assign dir_q  = (state_q == ST_FALL);
    assign dir_nx = (state_nx == ST_FALL);
    assign run    = (state_q != ST_IDLE);
endmodule

// File: rtl/pwm_duty_chan.sv
module pwm_duty_chan #(
    parameter int TMR_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [TMR_W-1:0] buf_val,
    input  logic [TMR_W-1:0] tmr,
    input  logic [TMR_W-1:0] period,
    output logic             pwm
);
    logic [TMR_W-1:0] act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    act_q <= '0;
        else if (load) act_q <= buf_val;
    end

    assign pwm = run && (act_q != '0) && ((act_q >= period) || (tmr < act_q));
endmodule

// File: rtl/pwm_event_unit.sv
module pwm_event_unit import pwmtb_pkg::*; #(
    parameter int TMR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    input  logic              zero_evt,
    input  logic              shot_end,
    input  logic [POST_W-1:0] post_n,
    input  logic [TMR_W-1:0]  tmr_nx,
    input  logic              dir_nx,
    input  logic [TMR_W-1:0]  cmp_val,
    input  logic              cmp_dir,
    output logic              irq,
    output logic              trig,
    output logic              done
);
    logic [POST_W-1:0] post_q;
    logic              post_hit;

    assign post_hit = zero_evt && (post_q == post_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            post_q <= '0;
            irq    <= 1'b0;
            trig   <= 1'b0;
            done   <= 1'b0;
        end else begin
            irq  <= post_hit;
            trig <= tick && (tmr_nx == cmp_val) && (dir_nx == cmp_dir);
            done <= shot_end;
            if (start)         post_q <= '0;
            else if (post_hit) post_q <= '0;
            else if (zero_evt) post_q <= post_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase import pwmtb_pkg::*; #(
    parameter int TMR_W  = 15,
    parameter int NUM_CH = 4,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NUM_CH-1:0] pwm_out,
    output logic [TMR_W-1:0]  tmr_value,
    output logic              tmr_dir,
    output logic              running,
    output logic              period_irq,
    output logic              adc_trig,
    output logic              oneshot_done
);
    ctrl_t            ctrl_q;
    ctrl_t            ctrl_wr;
    logic [TMR_W-1:0] per_q;
    logic [TMR_W-1:0] cmp_q;
    logic             cmp_dir_q;
    logic [TMR_W-1:0] dbuf_q [NUM_CH];

    logic wr_ctrl, start_p, stop_p, tick, duty_load;
    logic [TMR_W-1:0] tmr_nx;
    logic dir_nx, zero_evt, top_evt, shot_end;

    assign ctrl_wr = ctrl_t'(wr_data[CTRL_BITS-1:0]);
    assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
    assign start_p = wr_ctrl && ctrl_wr.en && !ctrl_q.en;
    assign stop_p  = wr_ctrl && !ctrl_wr.en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            per_q     <= '0;
            cmp_q     <= '0;
            cmp_dir_q <= 1'b0;
        end else begin
            if (wr_ctrl)       ctrl_q    <= ctrl_wr;
            else if (shot_end) ctrl_q.en <= 1'b0;
            if (wr_en && wr_addr == ADDR_W'(ADDR_PER)) per_q <= wr_data[TMR_W-1:0];
            if (wr_en && wr_addr == ADDR_W'(ADDR_CMP)) begin
                cmp_q     <= wr_data[TMR_W-1:0];
                cmp_dir_q <= wr_data[TMR_W];
            end
        end
    end

    pwm_prescaler u_presc (
        .clk(clk), .rst_n(rst_n), .run(running),
        .clr(start_p || stop_p), .sel(ctrl_q.presc), .tick(tick)
    );

    pwm_count_fsm #(.TMR_W(TMR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start_p), .stop(stop_p), .tick(tick),
        .mode(ctrl_q.mode), .period(per_q),
        .tmr_q(tmr_value), .tmr_nx(tmr_nx), .dir_q(tmr_dir), .dir_nx(dir_nx),
        .run(running), .zero_evt(zero_evt), .top_evt(top_evt), .shot_end(shot_end)
    );

    assign duty_load = start_p || zero_evt ||
                       (top_evt && ctrl_q.mode == MODE_UPDOWN_DBL);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dbuf_q[g] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(ADDR_DUTY0 + g))
                dbuf_q[g] <= wr_data[TMR_W-1:0];
        end

        pwm_duty_chan #(.TMR_W(TMR_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .load(duty_load), .run(running),
            .buf_val(dbuf_q[g]), .tmr(tmr_value), .period(per_q), .pwm(pwm_out[g])
        );
    end

    pwm_event_unit #(.TMR_W(TMR_W)) u_evt (
        .clk(clk), .rst_n(rst_n), .start(start_p), .tick(tick),
        .zero_evt(zero_evt), .shot_end(shot_end), .post_n(ctrl_q.post),
        .tmr_nx(tmr_nx), .dir_nx(dir_nx), .cmp_val(cmp_q), .cmp_dir(cmp_dir_q),
        .irq(period_irq), .trig(adc_trig), .done(oneshot_done)
    );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
    parameter int TMR_W  = 15,
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] pwm_out,
    input logic [TMR_W-1:0]  tmr_value,
    input logic              tmr_dir,
    input logic              running,
    input logic              period_irq,
    input logic              adc_trig,
    input logic              oneshot_done,
    input logic [TMR_W-1:0]  cmp_val,
    input logic              cmp_dir
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (tmr_value == '0 && !tmr_dir && pwm_out == '0)); // R6

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && tmr_value != $past(tmr_value)) |->
        (tmr_value == '0 || tmr_value == TMR_W'($past(tmr_value) + 1'b1) ||
         tmr_value == TMR_W'($past(tmr_value) - 1'b1))); // R3

    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        period_irq |-> (tmr_value == '0 && !tmr_dir)); // R10

    AST_TRIG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |-> (tmr_value == $past(cmp_val) && tmr_dir == $past(cmp_dir))); // R11

    AST_DONE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        oneshot_done |-> (!running && tmr_value == '0)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        oneshot_done |=> !oneshot_done); // R5
endmodule

bind pwm_timebase pwm_timebase_chk #(.TMR_W(TMR_W), .NUM_CH(NUM_CH)) chk_i (
    .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .tmr_value(tmr_value),
    .tmr_dir(tmr_dir), .running(running), .period_irq(period_irq),
    .adc_trig(adc_trig), .oneshot_done(oneshot_done),
    .cmp_val(cmp_q), .cmp_dir(cmp_dir_q)
);

// File: tb/pwm_timebase_tb_top.sv
`timescale 1ns/1ps
module pwm_timebase_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  pwm_out;
    logic [14:0] tmr_value;
    logic        tmr_dir, running, period_irq, adc_trig, oneshot_done;

    always #2 clk = ~clk;

    pwm_timebase dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_out(pwm_out), .tmr_value(tmr_value), .tmr_dir(tmr_dir), .running(running),
        .period_irq(period_irq), .adc_trig(adc_trig), .oneshot_done(oneshot_done)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    string cur_req = "R3";
    string pwm_req = "R9";

    // reference model state, built from the requirements
    int m_en, m_mode, m_presc, m_post, m_per, m_cmp, m_cdir;
    int m_buf[4];
    int m_act[4];
    int m_st, m_tmr, m_ps, m_pcnt;
    int m_irq, m_trig, m_done;

    function automatic int exp_pwm();
        int r = 0;
        for (int i = 0; i < 4; i++)
            if (m_st != 0 && m_act[i] != 0 && (m_act[i] >= m_per || m_tmr < m_act[i]))
                r |= (1 << i);
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_mode = 0; m_presc = 0; m_post = 0; m_per = 0; m_cmp = 0; m_cdir = 0;
            for (int i = 0; i < 4; i++) begin m_buf[i] = 0; m_act[i] = 0; end
            m_st = 0; m_tmr = 0; m_ps = 0; m_pcnt = 0; m_irq = 0; m_trig = 0; m_done = 0;
        end else begin
            bit wc, st, sp, run, tk, z, tp, se;
            int ns, nt, div;
            wc  = wr_en && wr_addr == 0;
            st  = wc && wr_data[0] && m_en == 0;
            sp  = wc && !wr_data[0];
            run = m_st != 0;
            div = 1 << (2 * m_presc);
            tk  = run && !st && !sp && (m_ps >= div - 1);
            ns = m_st; nt = m_tmr; z = 0; tp = 0; se = 0;
            if (sp) begin ns = 0; nt = 0; end
            else if (st) begin ns = 1; nt = 0; end
            else if (tk) begin
                if (m_st == 1) begin
                    if (m_tmr >= m_per) begin
                        if (m_mode == 0) begin nt = 0; z = 1; end
                        else if (m_mode == 1) begin nt = 0; z = 1; se = 1; ns = 0; end
                        else begin tp = 1; ns = 2; nt = (m_tmr == 0) ? 0 : m_tmr - 1; end
                    end else nt = m_tmr + 1;
                end else if (m_st == 2) begin
                    if (m_tmr <= 1) begin nt = 0; z = 1; ns = 1; end
                    else nt = m_tmr - 1;
                end
            end
            m_ps = (st || sp || !run || tk) ? 0 : m_ps + 1;
            if (st || z || (tp && m_mode == 3))
                for (int i = 0; i < 4; i++) m_act[i] = m_buf[i];
            m_irq = z && (m_pcnt == m_post);
            if (st) m_pcnt = 0;
            else if (m_irq) m_pcnt = 0;
            else if (z) m_pcnt = m_pcnt + 1;
            m_trig = tk && nt == m_cmp && ((ns == 2) == (m_cdir == 1));
            m_done = se;
            if (wc) begin
                m_en = wr_data[0]; m_mode = wr_data[2:1];
                m_presc = wr_data[4:3]; m_post = wr_data[8:5];
            end else if (se) m_en = 0;
            if (wr_en && wr_addr == 1) m_per = wr_data[14:0];
            if (wr_en && wr_addr == 2) begin m_cmp = wr_data[14:0]; m_cdir = wr_data[15]; end
            for (int i = 0; i < 4; i++)
                if (wr_en && wr_addr == 3 + i) m_buf[i] = wr_data[14:0];
            m_st = ns; m_tmr = nt;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(tmr_value == m_tmr, cur_req, "tmr_value", tmr_value, m_tmr);
        chk(tmr_dir == (m_st == 2), cur_req, "tmr_dir", tmr_dir, (m_st == 2));
        chk(int'(pwm_out) == exp_pwm(), pwm_req, "pwm_out", pwm_out, exp_pwm());
        chk(period_irq == m_irq, "R10", "period_irq", period_irq, m_irq);
        chk(adc_trig == m_trig, "R11", "adc_trig", adc_trig, m_trig);
        chk(oneshot_done == m_done, "R5", "oneshot_done", oneshot_done, m_done);
        chk(running == (m_st != 0), "R12", "running", running, (m_st != 0));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic run_n(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        step();
        wr_en = 1'b0;
    endtask

    function automatic int ctrl_word(int en, int mode, int presc, int post);
        return (post << 5) | (presc << 3) | (mode << 1) | en;
    endfunction

    function automatic int pick_duty(int per);
        int k = $urandom % 5;
        if (k == 0) return 0;          // R9 never active
        if (k == 1) return per;        // R9 always active
        if (k == 2) return per + 3;
        return ($urandom % (per > 0 ? per : 1)) + 1;
    endfunction

    task automatic setup(int mode, int presc, int post, int per, int cmp, int cdir);
        wr(0, ctrl_word(0, mode, presc, post));
        wr(1, per);
        wr(2, (cdir << 15) | cmp);
        for (int i = 0; i < 4; i++) wr(3 + i, pick_duty(per));
    endtask

    task automatic run_with_writes(int n, int per);
        for (int i = 0; i < n; i++) begin
            if (($urandom % 23) == 0) wr(3 + ($urandom % 4), pick_duty(per));
            else if (($urandom % 61) == 0) wr(2, (($urandom % 2) << 15) | ($urandom % (per + 1)));
            else step();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250917));
        @(negedge clk);
        // R1 reset values
        chk(pwm_out == 0 && tmr_value == 0 && !tmr_dir && !running, "R1", "reset outputs",
            {pwm_out, tmr_value, tmr_dir, running}, 0);
        chk(!period_irq && !adc_trig && !oneshot_done, "R1", "reset pulses",
            {period_irq, adc_trig, oneshot_done}, 0);
        @(negedge clk); rst_n = 1'b1;
        step();

        // R2 each prescale in free-running mode (R3)
        for (int p = 0; p < 4; p++) begin
            cur_req = (p == 0) ? "R3" : "R2";
            setup(0, p, 0, 3 + p, 2, 0);
            wr(0, ctrl_word(1, 0, p, 0));
            run_with_writes(p == 3 ? 700 : 150, 3 + p);
            wr(0, ctrl_word(0, 0, p, 0));
        end

        // R4 up/down, R7 buffered duty
        cur_req = "R4"; pwm_req = "R7";
        setup(2, 0, 1, 9, 5, 1);
        wr(0, ctrl_word(1, 2, 0, 1));
        run_with_writes(300, 9);
        wr(0, ctrl_word(0, 2, 0, 1));

        // R8 reload at turnaround
        pwm_req = "R8";
        setup(3, 1, 0, 6, 4, 0);
        wr(0, ctrl_word(1, 3, 1, 0));
        run_with_writes(400, 6);
        wr(0, ctrl_word(0, 3, 1, 0));
        pwm_req = "R9";

        // R5 single shot
        cur_req = "R5";
        for (int k = 0; k < 3; k++) begin
            setup(1, k % 2, 0, 5 + k, 3, 0);
            wr(0, ctrl_word(1, 1, k % 2, 0));
            run_with_writes(60, 5 + k);
            chk(running == 1'b0, "R5", "single shot stopped", running, 0);
        end

        // R6 disable mid-run
        cur_req = "R6";
        setup(0, 0, 2, 12, 7, 0);
        wr(0, ctrl_word(1, 0, 0, 2));
        run_n(17);
        wr(0, ctrl_word(0, 0, 0, 2));
        run_n(10);
        chk(tmr_value == 0 && pwm_out == 0, "R6", "held after stop", tmr_value, 0);

        // R10 postscale and random mixes
        cur_req = "R10";
        for (int it = 0; it < 24; it++) begin
            int mode = $urandom % 4;
            int pr   = $urandom % 3;
            int po   = $urandom % 16;
            int per  = 2 + ($urandom % 14);
            setup(mode, pr, po, per, $urandom % (per + 1), $urandom % 2);
            wr(0, ctrl_word(1, mode, pr, po));
            run_with_writes(250 + 60 * pr * per, per);
            wr(0, ctrl_word(0, mode, pr, po));
            run_n(3);
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule